// File: doc/BRIEF.md
# Sticky Reset Status Register

This block keeps a 16-bit record of why the chip was last reset and of related pin and configuration events. Each cause or event sets its own flag. The flag stays set until software writes a one to that bit position. Writing zero to a bit has no effect on it. An event that arrives in the same cycle as a clear of the same bit wins, so no event is lost. Internal reset sources share a pair of indicator bits with the external pins. An internal reset shows up as both of those bits set at once, and a dedicated flag per internal source tells the sources apart.

Two reset pins, power-on and hard, are watched by qualifiers. A qualifier raises that pin's glitch flag once the pin has stayed asserted for a parameterised number of cycles. The block also holds the low-power-mode field and the clock multiplier and divider fields, each set of fields behind its own lock bit. A write that tries to change a locked field leaves the field as it was and raises the illegal-change flag instead.

The asynchronous reset input is the power-on reset. It leaves only the power-on indicator set. Hard and soft reset events enter as ordinary single-cycle strobes and never clear flags that software has not acknowledged.

Top module: `rst_status_reg`

## Requirements
- R1: While rst_ni is low, and after it is released, the status word reads 0x0040, with only bit 6, the power-on indicator, set. The low-power-mode, multiplier and divider fields read their parameter reset values.
- R2: A register write clears every status bit whose write-data bit is 1. Bits written with 0 keep their value. The result is visible on reg_rdata_o after the clock edge that takes the write.
- R3: If a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R4: An external hard reset strobe sets bit 0. An external soft reset strobe sets bit 1 and also sets bit 12, the soft-reset glitch flag.
- R5: A strobe on internal source k (0 to N_INT-1) sets bit 2+k, and also sets bits 0, 1 and 12.
- R6: Bit 10 is set once por_pin_i has been high for GLITCH_CYC consecutive clock edges, and bit 11 is set the same way for hrst_pin_i. A pin that is high for fewer edges sets nothing.
- R7: A low-power-mode write with its lock bit set and data different from lpm_o sets bit 9, the illegal-change flag, and leaves lpm_o unchanged.
- R8: A multiplier/divider write with their shared lock bit set, where either data value differs from the current value, sets bit 9 and leaves mf_o and divf_o unchanged.
- R9: An unlocked write loads the field and does not touch bit 9. A locked write of the value already held does not set bit 9.
- R10: Bits 7, 8, 13, 14 and 15 always read zero, and writes to them have no effect.
- R11: Once set, a flag holds through later events of any kind, including repeated reset strobes, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| ext_hard_evt_i | input | 1 | External hard reset event strobe |
| ext_soft_evt_i | input | 1 | External soft reset event strobe |
| int_evt_i | input | N_INT | Internal reset source strobes |
| por_pin_i | input | 1 | Power-on reset pin level, synchronised, active high |
| hrst_pin_i | input | 1 | Hard reset pin level, synchronised, active high |
| reg_wr_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 16 | Write data, where a 1 clears the bit |
| reg_rdata_o | output | 16 | Status word |
| lpm_wr_i | input | 1 | Low-power-mode field write strobe |
| lpm_lock_i | input | 1 | Low-power-mode lock |
| lpm_wdata_i | input | LPM_W | Low-power-mode write data |
| lpm_o | output | LPM_W | Low-power-mode field |
| pll_wr_i | input | 1 | Multiplier/divider write strobe |
| pll_lock_i | input | 1 | Multiplier/divider shared lock |
| mf_wdata_i | input | MF_W | Multiplier write data |
| divf_wdata_i | input | DIVF_W | Divider write data |
| mf_o | output | MF_W | Multiplier field |
| divf_o | output | DIVF_W | Divider field |

## Verification
The assertions assume that every event strobe and write input is synchronous to clk_i and that each strobe describes one event per cycle. They also assume that the pin inputs have already been brought into the clock domain. The bench changes every input only on the falling edge and holds each strobe for exactly one rising edge. It samples on the next falling edge, so each event or write lands in a known cycle. Cases where a set and a clear collide are driven deliberately in the same cycle, because the set-wins priority is the one ordering the assertions rely on.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int REG_W       = 16;
  localparam int B_EXT_HARD  = 0;
  localparam int B_EXT_SOFT  = 1;
  localparam int B_INT_BASE  = 2;
  localparam int B_PWR_ON    = 6;
  localparam int B_ILL_CHG   = 9;
  localparam int B_GL_POR    = 10;
  localparam int B_GL_HRST   = 11;
  localparam int B_GL_SRST   = 12;
  localparam int MAX_INT     = B_PWR_ON - B_INT_BASE;
  typedef logic [REG_W-1:0] rsr_word_t;
  localparam rsr_word_t RSV_MASK = 16'hE180;
  localparam rsr_word_t POR_VAL  = rsr_word_t'(1) << B_PWR_ON;
endpackage

// File: rtl/rsr_glitch_qual.sv
module rsr_glitch_qual #(
  parameter int CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic hit_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  // saturating run-length counter; hit fires once per assertion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!pin_i)                cnt_q <= '0;
    else if (cnt_q != CW'(CYC))     cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = pin_i && (cnt_q == CW'(CYC - 1));
endmodule

// File: rtl/rsr_lock_guard.sv
module rsr_lock_guard #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         lock_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic         viol_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_q <= RST_VAL;
    else if (wr_i && !lock_i) q_q <= wdata_i;
  end

  assign q_o    = q_q;
  assign viol_o = wr_i && lock_i && (wdata_i != q_q);
endmodule

// File: rtl/rsr_flag_bank.sv
module rsr_flag_bank
  import rsr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  rsr_word_t set_i,
  input  rsr_word_t clr_i,
  output rsr_word_t q_o
);
  rsr_word_t q_q;

  // set has priority over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= POR_VAL;
    else         q_q <= ((q_q & ~clr_i) | set_i) & ~RSV_MASK;
  end

  assign q_o = q_q;
endmodule

// File: rtl/rst_status_reg.sv
module rst_status_reg
  import rsr_pkg::*;
#(
  parameter int              N_INT      = 4,
  parameter int              GLITCH_CYC = 4,
  parameter int              LPM_W      = 2,
  parameter int              MF_W       = 12,
  parameter int              DIVF_W     = 5,
  parameter logic [LPM_W-1:0]  LPM_RST  = '0,
  parameter logic [MF_W-1:0]   MF_RST   = '0,
  parameter logic [DIVF_W-1:0] DIVF_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_hard_evt_i,
  input  logic              ext_soft_evt_i,
  input  logic [N_INT-1:0]  int_evt_i,
  input  logic              por_pin_i,
  input  logic              hrst_pin_i,
  input  logic              reg_wr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic              lpm_wr_i,
  input  logic              lpm_lock_i,
  input  logic [LPM_W-1:0]  lpm_wdata_i,
  output logic [LPM_W-1:0]  lpm_o,
  input  logic              pll_wr_i,
  input  logic              pll_lock_i,
  input  logic [MF_W-1:0]   mf_wdata_i,
  input  logic [DIVF_W-1:0] divf_wdata_i,
  output logic [MF_W-1:0]   mf_o,
  output logic [DIVF_W-1:0] divf_o
);
  localparam int N_PIN  = 2;
  localparam int PLL_W  = MF_W + DIVF_W;
  localparam int N_USE  = (N_INT < MAX_INT) ? N_INT : MAX_INT;

  logic [N_PIN-1:0] pin_lvl, pin_hit;
  logic             any_int, lpm_viol, pll_viol;
  logic [PLL_W-1:0] pll_q;
  rsr_word_t        set_vec, clr_vec, flags;

  assign pin_lvl = {hrst_pin_i, por_pin_i};

  for (genvar g = 0; g < N_PIN; g++) begin : g_qual
    rsr_glitch_qual #(.CYC(GLITCH_CYC)) i_qual (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_lvl[g]),
      .hit_o (pin_hit[g])
    );
  end

  rsr_lock_guard #(.W(LPM_W), .RST_VAL(LPM_RST)) i_lpm_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (lpm_wr_i),
    .lock_i (lpm_lock_i),
    .wdata_i(lpm_wdata_i),
    .q_o    (lpm_o),
    .viol_o (lpm_viol)
  );

  rsr_lock_guard #(.W(PLL_W), .RST_VAL({MF_RST, DIVF_RST})) i_pll_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (pll_wr_i),
    .lock_i (pll_lock_i),
    .wdata_i({mf_wdata_i, divf_wdata_i}),
    .q_o    (pll_q),
    .viol_o (pll_viol)
  );

  assign mf_o   = pll_q[PLL_W-1:DIVF_W];
  assign divf_o = pll_q[DIVF_W-1:0];

  assign any_int = |int_evt_i;

  always_comb begin
    set_vec = '0;
    // internal sources alias onto both external indicators
    set_vec[B_EXT_HARD] = ext_hard_evt_i | any_int;
    set_vec[B_EXT_SOFT] = ext_soft_evt_i | any_int;
    set_vec[B_GL_SRST]  = ext_soft_evt_i | any_int;
    for (int k = 0; k < N_USE; k++) set_vec[B_INT_BASE + k] = int_evt_i[k];
    set_vec[B_ILL_CHG]  = lpm_viol | pll_viol;
    set_vec[B_GL_POR]   = pin_hit[0];
    set_vec[B_GL_HRST]  = pin_hit[1];
  end

  assign clr_vec = reg_wr_i ? reg_wdata_i : '0;

  rsr_flag_bank i_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .q_o   (flags)
  );

  assign reg_rdata_o = flags;
endmodule

// File: rtl/rst_status_reg_chk.sv
module rst_status_reg_chk #(
  parameter int N_INT = 4,
  parameter int LPM_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_hard_evt_i,
  input logic             ext_soft_evt_i,
  input logic [N_INT-1:0] int_evt_i,
  input logic             reg_wr_i,
  input logic [15:0]      reg_wdata_i,
  input logic [15:0]      reg_rdata_o,
  input logic             lpm_wr_i,
  input logic             lpm_lock_i,
  input logic [LPM_W-1:0] lpm_wdata_i,
  input logic [LPM_W-1:0] lpm_o
);
  a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & 16'hE180) == 16'h0000);

  a_r4_hard_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_hard_evt_i |=> reg_rdata_o[0]);

  a_r5_int_sets_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|int_evt_i) |=> (reg_rdata_o[0] && reg_rdata_o[1] && reg_rdata_o[12]));

  a_r2_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[1] && !ext_soft_evt_i && !(|int_evt_i)) |=> !reg_rdata_o[1]);

  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[1] && !(reg_wr_i && reg_wdata_i[1])) |=> reg_rdata_o[1]);

  a_r7_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpm_wr_i && lpm_lock_i) |=> $stable(lpm_o));

  a_r7_flag_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpm_wr_i && lpm_lock_i && (lpm_wdata_i != lpm_o)) |=> reg_rdata_o[9]);
endmodule

bind rst_status_reg rst_status_reg_chk #(.N_INT(N_INT), .LPM_W(LPM_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ext_hard_evt_i(ext_hard_evt_i),
  .ext_soft_evt_i(ext_soft_evt_i),
  .int_evt_i     (int_evt_i),
  .reg_wr_i      (reg_wr_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .lpm_wr_i      (lpm_wr_i),
  .lpm_lock_i    (lpm_lock_i),
  .lpm_wdata_i   (lpm_wdata_i),
  .lpm_o         (lpm_o)
);

// File: tb/test_rst_status_reg.sv
`timescale 1ns/1ps
module test_rst_status_reg;
  localparam int N_INT = 4;
  localparam int GC    = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_hard_evt_i = 1'b0, ext_soft_evt_i = 1'b0;
  logic [3:0]  int_evt_i = '0;
  logic        por_pin_i = 1'b0, hrst_pin_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        lpm_wr_i = 1'b0, lpm_lock_i = 1'b0;
  logic [1:0]  lpm_wdata_i = '0;
  logic [1:0]  lpm_o;
  logic        pll_wr_i = 1'b0, pll_lock_i = 1'b0;
  logic [11:0] mf_wdata_i = '0;
  logic [4:0]  divf_wdata_i = '0;
  logic [11:0] mf_o;
  logic [4:0]  divf_o;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  rst_status_reg #(.N_INT(N_INT), .GLITCH_CYC(GC)) i_rst_status_reg (
    .clk_i(clk), .rst_ni(rst_ni),
    .ext_hard_evt_i(ext_hard_evt_i), .ext_soft_evt_i(ext_soft_evt_i),
    .int_evt_i(int_evt_i), .por_pin_i(por_pin_i), .hrst_pin_i(hrst_pin_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .lpm_wr_i(lpm_wr_i), .lpm_lock_i(lpm_lock_i), .lpm_wdata_i(lpm_wdata_i),
    .lpm_o(lpm_o), .pll_wr_i(pll_wr_i), .pll_lock_i(pll_lock_i),
    .mf_wdata_i(mf_wdata_i), .divf_wdata_i(divf_wdata_i),
    .mf_o(mf_o), .divf_o(divf_o)
  );

  // {expected[38:23], wdata[22:7], wr[6], int[5:2], soft[1], hard[0]}
  localparam int NV = 12;
  localparam logic [38:0] VEC [0:NV-1] = '{
    {16'h0000, 16'h0040, 1'b1, 4'b0000, 1'b0, 1'b0}, // R2 clear power-on bit
    {16'h0001, 16'h0000, 1'b0, 4'b0000, 1'b0, 1'b1}, // R4 hard
    {16'h1003, 16'h0000, 1'b0, 4'b0000, 1'b1, 1'b0}, // R4 soft + glitch flag
    {16'h1003, 16'h0000, 1'b1, 4'b0000, 1'b0, 1'b0}, // R2 zeros keep
    {16'h0000, 16'h1003, 1'b1, 4'b0000, 1'b0, 1'b0}, // R2 clear
    {16'h1013, 16'h0000, 1'b0, 4'b0100, 1'b0, 1'b0}, // R5 internal 2
    {16'h1001, 16'h0013, 1'b1, 4'b0000, 1'b0, 1'b1}, // R3 set wins bit 0
    {16'h0000, 16'hFFFF, 1'b1, 4'b0000, 1'b0, 1'b0}, // R2 clear all
    {16'h1023, 16'h0020, 1'b1, 4'b1000, 1'b0, 1'b0}, // R3 R5 internal 3 vs clear
    {16'h1023, 16'hE180, 1'b1, 4'b0000, 1'b0, 1'b0}, // R10 reserved write
    {16'h1023, 16'h0000, 1'b0, 4'b0000, 1'b0, 1'b1}, // R11 sticky
    {16'h0000, 16'hFFFF, 1'b1, 4'b0000, 1'b0, 1'b0}  // R2 clear all
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] w);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_wdata_i = w;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", 32'(reg_rdata_o), 32'h0040);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 word after release", 32'(reg_rdata_o), 32'h0040);
    check("R1 fields default", {lpm_o, mf_o, divf_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ext_hard_evt_i = VEC[i][0];
      ext_soft_evt_i = VEC[i][1];
      int_evt_i      = VEC[i][5:2];
      reg_wr_i       = VEC[i][6];
      reg_wdata_i    = VEC[i][22:7];
      @(negedge clk);
      ext_hard_evt_i = 1'b0; ext_soft_evt_i = 1'b0; int_evt_i = '0;
      reg_wr_i = 1'b0; reg_wdata_i = '0;
      check($sformatf("R2 R3 R4 R5 R10 R11 vector %0d", i), 32'(reg_rdata_o), 32'(VEC[i][38:23]));
    end

    // R6 short pulse on the power-on pin
    @(negedge clk); por_pin_i = 1'b1;
    repeat (GC - 1) @(negedge clk);
    por_pin_i = 1'b0;
    @(negedge clk);
    check("R6 short por pulse", 32'(reg_rdata_o[10]), 32'h0);
    por_pin_i = 1'b1;
    repeat (GC) @(negedge clk);
    check("R6 long por pulse", 32'(reg_rdata_o), 32'h0400);
    repeat (3) @(negedge clk);
    por_pin_i = 1'b0;
    reg_write(16'h0400);
    check("R6 por flag cleared while pin idle", 32'(reg_rdata_o), 32'h0);
    hrst_pin_i = 1'b1;
    repeat (GC) @(negedge clk);
    hrst_pin_i = 1'b0;
    check("R6 long hard pin pulse", 32'(reg_rdata_o), 32'h0800);
    reg_write(16'h0800);

    // R9 unlocked write
    @(negedge clk); lpm_wr_i = 1'b1; lpm_wdata_i = 2'b10;
    @(negedge clk); lpm_wr_i = 1'b0;
    check("R9 unlocked lpm load", 32'(lpm_o), 32'h2);
    check("R9 no flag on unlocked write", 32'(reg_rdata_o), 32'h0);
    // R7 locked change
    @(negedge clk); lpm_wr_i = 1'b1; lpm_lock_i = 1'b1; lpm_wdata_i = 2'b01;
    @(negedge clk); lpm_wr_i = 1'b0;
    check("R7 locked lpm held", 32'(lpm_o), 32'h2);
    check("R7 illegal-change flag", 32'(reg_rdata_o), 32'h0200);
    reg_write(16'h0200);
    // R9 locked write of same value
    @(negedge clk); lpm_wr_i = 1'b1; lpm_wdata_i = 2'b10;
    @(negedge clk); lpm_wr_i = 1'b0; lpm_lock_i = 1'b0;
    check("R9 locked same value no flag", 32'(reg_rdata_o), 32'h0);
    // R8 locked divider change
    @(negedge clk); pll_wr_i = 1'b1; mf_wdata_i = 12'h00A; divf_wdata_i = 5'h03;
    @(negedge clk); pll_wr_i = 1'b0;
    check("R9 unlocked mf/divf load", {mf_o, divf_o}, {12'h00A, 5'h03});
    @(negedge clk); pll_wr_i = 1'b1; pll_lock_i = 1'b1; divf_wdata_i = 5'h07;
    @(negedge clk); pll_wr_i = 1'b0; pll_lock_i = 1'b0;
    check("R8 locked divider held", {mf_o, divf_o}, {12'h00A, 5'h03});
    check("R8 illegal-change flag", 32'(reg_rdata_o), 32'h0200);

    // R1 reset mid-run
    @(negedge clk); ext_hard_evt_i = 1'b1;
    @(negedge clk); ext_hard_evt_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk);
    check("R1 power-on reset word", 32'(reg_rdata_o), 32'h0040);
    check("R1 power-on reset fields", {lpm_o, mf_o, divf_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule